// File: doc/BRIEF.md
# Fixed-Point Exception Flag Register

This block keeps the five exception flags of a fixed-point execution unit: a sticky summary overflow, an overflow flag, a carry flag, and the 32-bit-mode copies of overflow and carry. It does not compute these flags from operands. The execution pipeline computes the new flag values and sends them here. Each cycle the block applies at most one update request from the pipeline and decides which flags change.

A request carries four things:

- a one-hot operation class: explicit register write, arithmetic, overflow-as-carry add, or no-effect;
- separate write strobes for the carry pair and the overflow pair;
- the new carry and overflow values, in 64-bit and 32-bit forms;
- for explicit writes, a full 64-bit register image.

The current flags are always visible as a packed 64-bit register image. Bit 0 of that image is the most significant bit, and all bits other than the five flags read as zero.

Top module: `fx_flag_reg`

## Requirements
- R1: While reset is asserted, and after it is released with no request, all five flags are 0 and the image reads all zero.
- R2: In the image (bit 0 = MSB, so bit k is vector index 63-k), the flags sit at these positions: summary overflow at bit 32, overflow at 33, carry at 34, overflow32 at 44, carry32 at 45. Every other bit reads 0.
- R3: An explicit write (class 4'b0001) loads all five flags from the matching bits of the write image, exactly as supplied. This includes summary overflow 0 together with overflow 1. All other write-image bits are ignored.
- R4: An arithmetic request (class 4'b0010) with the overflow strobe loads overflow and overflow32. If the new overflow is 1, summary overflow becomes 1.
- R5: Once summary overflow is 1, only an explicit write can return it to 0.
- R6: An arithmetic request with the carry strobe loads carry and carry32 in the same cycle. Without the overflow strobe, as for arithmetic shift-right operations, overflow, overflow32 and summary overflow stay unchanged.
- R7: An overflow-as-carry add (class 4'b0100) loads overflow and overflow32 and ignores both strobes. It leaves summary overflow, carry and carry32 unchanged.
- R8: A no-effect request (class 4'b1000), such as a compare, changes no flag, whatever the strobes and data.
- R9: A class field that is not exactly one-hot, including all zero, changes no flag.
- R10: An arithmetic request without the carry strobe leaves carry and carry32 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_cls | input | 4 | One-hot class: [0] explicit write, [1] arithmetic, [2] overflow-as-carry add, [3] no-effect |
| ca_we | input | 1 | Carry-pair write strobe (arithmetic class) |
| ov_we | input | 1 | Overflow-pair write strobe (arithmetic class) |
| ca_in | input | 1 | New carry value |
| ca32_in | input | 1 | New 32-bit-mode carry value |
| ov_in | input | 1 | New overflow value |
| ov32_in | input | 1 | New 32-bit-mode overflow value |
| wr_img | input | 64 | Register image supplied by an explicit write |
| flag_img | output | 64 | Current flags as a packed register image |

## Verification
Every request takes effect at the clock edge that samples it. The image is decoded combinationally from the flag registers, so the result of a request shows on `flag_img` one edge after the request is driven. The bench drives each request on a falling edge and compares the image on the following falling edge, which lies half a period after the update. Before each request it loads one of the 32 possible flag states with an explicit write whose unused bits are random. That load is checked on the same one-edge schedule, so every class, strobe and data combination is tested against a known starting state.

// File: rtl/fx_flag_reg.sv
module fx_flag_reg #(
  parameter int IMG_W    = 64,
  parameter int SO_POS   = 32,
  parameter int OV_POS   = 33,
  parameter int CA_POS   = 34,
  parameter int OV32_POS = 44,
  parameter int CA32_POS = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_cls,
  input  logic             ca_we,
  input  logic             ov_we,
  input  logic             ca_in,
  input  logic             ca32_in,
  input  logic             ov_in,
  input  logic             ov32_in,
  input  logic [IMG_W-1:0] wr_img,
  output logic [IMG_W-1:0] flag_img
);
  localparam int SO_I   = IMG_W - 1 - SO_POS;
  localparam int OV_I   = IMG_W - 1 - OV_POS;
  localparam int CA_I   = IMG_W - 1 - CA_POS;
  localparam int OV32_I = IMG_W - 1 - OV32_POS;
  localparam int CA32_I = IMG_W - 1 - CA32_POS;

  logic so, ov, ca, ov32, ca32;

  wire is_wr = (op_cls == 4'b0001);
  wire is_ar = (op_cls == 4'b0010);
  wire is_oc = (op_cls == 4'b0100);
  wire ld_ca = is_ar & ca_we;
  wire ld_ov = (is_ar & ov_we) | is_oc;
  wire set_so = is_ar & ov_we & ov_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so <= 1'b0; ov <= 1'b0; ca <= 1'b0; ov32 <= 1'b0; ca32 <= 1'b0;
    end else if (is_wr) begin
      so   <= wr_img[SO_I];
      ov   <= wr_img[OV_I];
      ca   <= wr_img[CA_I];
      ov32 <= wr_img[OV32_I];
      ca32 <= wr_img[CA32_I];
    end else begin
      if (ld_ca) begin
        ca   <= ca_in;
        ca32 <= ca32_in;
      end
      if (ld_ov) begin
        ov   <= ov_in;
        ov32 <= ov32_in;
      end
      if (set_so) so <= 1'b1;
    end
  end

  always_comb begin
    flag_img         = '0;
    flag_img[SO_I]   = so;
    flag_img[OV_I]   = ov;
    flag_img[CA_I]   = ca;
    flag_img[OV32_I] = ov32;
    flag_img[CA32_I] = ca32;
  end

  p_wr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> (so == $past(wr_img[SO_I])) && (ov == $past(wr_img[OV_I])) &&
              (ca == $past(wr_img[CA_I])) && (ov32 == $past(wr_img[OV32_I])) &&
              (ca32 == $past(wr_img[CA32_I])));

  p_so_follows_ov_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ar && ov_we && ov_in) |=> so && ov);

  p_so_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (so && !is_wr) |=> so);

  p_shift_keeps_ov_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ar && !ov_we) |=> $stable(ov) && $stable(ov32) && $stable(so));

  p_ovca_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_oc |=> $stable(so) && $stable(ca) && $stable(ca32) && (ov == $past(ov_in)));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'b1000) |=> $stable(flag_img));

  p_bad_cls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(op_cls) != 1) |=> $stable(flag_img));

  p_no_ca_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ar && !ca_we) |=> $stable(ca) && $stable(ca32));
endmodule

// File: tb/fx_flag_reg_tb.sv
module fx_flag_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_cls = 4'b0000;
  logic        ca_we = 1'b0, ov_we = 1'b0;
  logic        ca_in = 1'b0, ca32_in = 1'b0, ov_in = 1'b0, ov32_in = 1'b0;
  logic [63:0] wr_img = '0;
  logic [63:0] flag_img;

  int n_vec = 0;
  int n_bad = 0;
  logic m_so, m_ov, m_ca, m_ov32, m_ca32;

  always #2 clk = ~clk;

  fx_flag_reg u_dut (
    .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .ca_we(ca_we), .ov_we(ov_we),
    .ca_in(ca_in), .ca32_in(ca32_in), .ov_in(ov_in), .ov32_in(ov32_in),
    .wr_img(wr_img), .flag_img(flag_img)
  );

  function automatic logic [63:0] mk_img(logic so, logic ov, logic ca, logic ov32, logic ca32);
    logic [63:0] v = '0;
    v[63-32] = so; v[63-33] = ov; v[63-34] = ca; v[63-44] = ov32; v[63-45] = ca32;
    return v;
  endfunction

  task automatic check(string tag);
    logic [63:0] exp = mk_img(m_so, m_ov, m_ca, m_ov32, m_ca32);
    n_vec++;
    if (flag_img !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, flag_img, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    {m_so, m_ov, m_ca, m_ov32, m_ca32} = '0;
    wr_img = {$urandom, $urandom};
    op_cls = 4'b0001;
    repeat (3) @(negedge clk);
    check("R1 reset");
    op_cls = 4'b0000;
    rst_n = 1'b1;
    step();
    check("R1 after release");

    for (int s = 0; s < 32; s++) begin
      for (int c = 0; c < 16; c++) begin
        for (int w = 0; w < 4; w++) begin
          for (int d = 0; d < 16; d++) begin
            string tag;
            // R3 R2: load start state, unused image bits random
            wr_img = {$urandom, $urandom};
            {wr_img[63-32], wr_img[63-33], wr_img[63-34], wr_img[63-44], wr_img[63-45]} = 5'(s);
            op_cls = 4'b0001;
            {m_so, m_ov, m_ca, m_ov32, m_ca32} = 5'(s);
            step();
            check("R3 R2 explicit write");

            op_cls = 4'(c);
            {ca_we, ov_we} = 2'(w);
            {ca_in, ca32_in, ov_in, ov32_in} = 4'(d);
            wr_img = {$urandom, $urandom};
            case (c)
              1: begin
                tag = "R3 write";
                {m_so, m_ov, m_ca, m_ov32, m_ca32} =
                  {wr_img[63-32], wr_img[63-33], wr_img[63-34], wr_img[63-44], wr_img[63-45]};
              end
              2: begin
                tag = "R4 R5 R6 R10 arithmetic";
                if (ca_we) begin m_ca = ca_in; m_ca32 = ca32_in; end
                if (ov_we) begin
                  m_ov = ov_in; m_ov32 = ov32_in;
                  if (ov_in) m_so = 1'b1;
                end
              end
              4: begin
                tag = "R7 R5 ov-as-carry";
                m_ov = ov_in; m_ov32 = ov32_in;
              end
              8: tag = "R8 no-effect";
              default: tag = "R9 bad class";
            endcase
            step();
            check(tag);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule